// File: doc/BRIEF.md
# Nibble-Bus Memory Read Target

This block is the target side of a single-byte memory read carried over a 4-bit multiplexed bus. The bus is qualified by an active-low frame strobe. The block watches for a start code and checks a device-select nibble against its strap input. It then collects a 28-bit address one nibble at a time and checks the size nibble. After a two-clock bus turnaround, it drives a ready-sync nibble and the two halves of the data byte. A final all-ones nibble follows, and then it releases the bus.

The nibble bus appears at the block edge as three signals: an input, an output value and an output enable. A bus wrapper can merge them into one bidirectional pin. The block fetches the byte through a plain synchronous read port: it raises a one-clock request with the address, and the memory returns the byte on the following clock. Every field is sampled on, or presented for, the rising clock edge.

Top module: `nbt_read_target`

## Requirements
- R1: While reset is held and directly after it is released, `bus_oe` and `mem_req` are both low.
- R2: A frame begins only on a clock where `frame_n` is low and `bus_in` is 4'b1101. A 1101 nibble with `frame_n` high, or any other nibble with `frame_n` low, starts nothing.
- R3: When `frame_n` stays low for several clocks, only the nibble sampled on the last low clock decides whether a frame starts.
- R4: The clock after the start carries a select nibble. If it differs from `dev_id`, the block raises neither `mem_req` nor `bus_oe` for that frame.
- R5: The seven clocks after the select carry the address, most significant nibble first. On the 10th clock of the frame (clock 1 is the start clock), `mem_req` is high for exactly one clock and `mem_addr` holds the full address.
- R6: Clock 10 carries the size nibble. Any value other than 4'b0000 ends the frame without `bus_oe` ever going high.
- R7: On an accepted frame, `bus_oe` is low on clocks 11 and 12 and high on clocks 13 through 16 only.
- R8: On clocks 13, 14, 15 and 16, `bus_out` carries 4'b0000, then the data byte's bits [3:0], then its bits [7:4], then 4'b1111.
- R9: The byte is taken from `mem_data` on clock 11, the clock after the request, and is held in a register. Changes on `mem_data` after that do not alter the driven nibbles.
- R10: A low `frame_n` at any point in a frame aborts it. If the nibble on that clock is 1101, a new frame starts at once; otherwise the block waits idle with no request and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe |
| bus_in | input | 4 | Nibble bus as seen at the pins |
| dev_id | input | 4 | Device select strap |
| bus_out | output | 4 | Nibble driven when `bus_oe` is high |
| bus_oe | output | 1 | Output enable for the nibble bus |
| mem_req | output | 1 | One-clock memory read request |
| mem_addr | output | 28 | Read address, valid while `mem_req` is high |
| mem_data | input | 8 | Read data, valid the clock after `mem_req` |

## Verification
The request is registered from the state reached at the 9th edge, so it is visible during clock 10. The enable and the response nibbles are decoded from the state after edges 12 to 15, so they are visible during clocks 13 to 16. The bench drives each clock's inputs on the falling edge. At that same falling edge it checks the outputs that belong to that clock, and those outputs reflect every rising edge before it. The bench's memory model returns the correct byte only on the clock after a request and inverts its output on every other clock. A design that does not latch the byte on clock 11 therefore fails the data-nibble checks.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_SIZE,
    ST_TARH,
    ST_TART,
    ST_SYNC,
    ST_DATA,
    ST_TAIL
  } nbt_state_e;

  localparam logic [NIB_W-1:0] CODE_START = 4'b1101;
  localparam logic [NIB_W-1:0] CODE_READY = 4'b0000;
  localparam logic [NIB_W-1:0] CODE_ONE   = 4'b0000;
  localparam logic [NIB_W-1:0] CODE_IDLE  = 4'b1111;

  function automatic logic is_start(input logic [NIB_W-1:0] nib);
    return nib == CODE_START;
  endfunction

  function automatic logic size_ok(input logic [NIB_W-1:0] nib);
    return nib == CODE_ONE;
  endfunction

  function automatic logic drives_bus(input nbt_state_e st);
    return (st == ST_SYNC) || (st == ST_DATA) || (st == ST_TAIL);
  endfunction

endpackage

// File: rtl/nbt_frame_fsm.sv
module nbt_frame_fsm
  import nbt_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int DATA_NIBS = 2,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  input  logic [NIB_W-1:0] dev_id,
  output nbt_state_e       state,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_start,
  output logic             ev_sel_hit,
  output logic             ev_sel_miss,
  output logic             ev_size_bad,
  output logic             ev_shift,
  output logic             ev_cap
);

  nbt_state_e       state_n;
  logic [CNT_W-1:0] cnt_n;

  assign ev_start    = !frame_n && is_start(nib);
  assign ev_sel_hit  = frame_n && (state == ST_SEL) && (nib == dev_id);
  assign ev_sel_miss = frame_n && (state == ST_SEL) && (nib != dev_id);
  assign ev_size_bad = frame_n && (state == ST_SIZE) && !size_ok(nib);
  assign ev_shift    = frame_n && (state == ST_ADDR);
  assign ev_cap      = frame_n && (state == ST_TARH);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    if (!frame_n) begin
      state_n = ev_start ? ST_SEL : ST_IDLE;
      cnt_n   = '0;
    end else begin
      unique case (state)
        ST_IDLE: state_n = ST_IDLE;
        ST_SEL: begin
          state_n = ev_sel_hit ? ST_ADDR : ST_IDLE;
          cnt_n   = '0;
        end
        ST_ADDR: begin
          if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
            state_n = ST_SIZE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_SIZE: state_n = ev_size_bad ? ST_IDLE : ST_TARH;
        ST_TARH: state_n = ST_TART;
        ST_TART: state_n = ST_SYNC;
        ST_SYNC: begin
          state_n = ST_DATA;
          cnt_n   = '0;
        end
        ST_DATA: begin
          if (cnt == CNT_W'(DATA_NIBS - 1)) begin
            state_n = ST_TAIL;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_TAIL: state_n = ST_IDLE;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

endmodule

// File: rtl/nbt_addr_shift.sv
module nbt_addr_shift
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [NIB_W-1:0]  nib,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (shift_en) begin
      addr <= {addr[ADDR_W-NIB_W-1:0], nib};
    end
  end

endmodule

// File: rtl/nbt_resp_drive.sv
module nbt_resp_drive
  import nbt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] rd_data,
  input  nbt_state_e        state,
  input  logic [CNT_W-1:0]  cnt,
  output logic [NIB_W-1:0]  bus_out,
  output logic              bus_oe
);

  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam int DI_W      = (DATA_NIBS > 1) ? $clog2(DATA_NIBS) : 1;

  logic [DATA_W-1:0] data_q;
  logic [NIB_W-1:0]  nibs [DATA_NIBS];
  logic [DI_W-1:0]   nib_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q <= rd_data;
    end
  end

  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_nib
    assign nibs[g] = data_q[g*NIB_W +: NIB_W];
  end

  assign nib_idx = cnt[DI_W-1:0];

  always_comb begin
    unique case (state)
      ST_SYNC: bus_out = CODE_READY;
      ST_DATA: bus_out = nibs[nib_idx];
      default: bus_out = CODE_IDLE;
    endcase
  end

  assign bus_oe = drives_bus(state);

endmodule

// File: rtl/nbt_read_target.sv
module nbt_read_target
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  input  logic [3:0]        dev_id,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data
);

  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CNT_W     = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;

  nbt_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             ev_start;
  logic             ev_sel_hit;
  logic             ev_sel_miss;
  logic             ev_size_bad;
  logic             ev_shift;
  logic             ev_cap;

  nbt_frame_fsm #(
    .ADDR_NIBS(ADDR_NIBS),
    .DATA_NIBS(DATA_NIBS),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .nib        (bus_in),
    .dev_id     (dev_id),
    .state      (state),
    .cnt        (cnt),
    .ev_start   (ev_start),
    .ev_sel_hit (ev_sel_hit),
    .ev_sel_miss(ev_sel_miss),
    .ev_size_bad(ev_size_bad),
    .ev_shift   (ev_shift),
    .ev_cap     (ev_cap)
  );

  nbt_addr_shift #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(ev_shift),
    .nib     (bus_in),
    .addr    (mem_addr)
  );

  nbt_resp_drive #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (ev_cap),
    .rd_data(mem_data),
    .state  (state),
    .cnt    (cnt),
    .bus_out(bus_out),
    .bus_oe (bus_oe)
  );

  assign mem_req = (state == ST_SIZE);

endmodule

// File: rtl/nbt_read_target_chk.sv
module nbt_read_target_chk #(
  parameter int DATA_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] bus_out,
  input logic       bus_oe,
  input logic       mem_req,
  input logic       ev_start,
  input logic       ev_sel_miss,
  input logic       ev_size_bad
);

  localparam int DATA_NIBS = DATA_W / 4;
  localparam int RUN_MAX   = DATA_NIBS + 1;

  logic [7:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       oe_run <= '0;
    else if (!bus_oe) oe_run <= '0;
    else if (oe_run != 8'hFF) oe_run <= oe_run + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !bus_oe && !mem_req);

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4
  sel_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_miss |=> !mem_req && !bus_oe);

  // R6
  size_bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_size_bad |=> !bus_oe);

  // R8
  oe_rise_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> bus_out == 4'b0000);

  // R8
  oe_fall_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> $past(bus_out) == 4'b1111);

  // R7
  oe_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> oe_run <= 8'(RUN_MAX));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && !ev_start) |=> !bus_oe && !mem_req);

endmodule

bind nbt_read_target nbt_read_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe),
  .mem_req    (mem_req),
  .ev_start   (ev_start),
  .ev_sel_miss(ev_sel_miss),
  .ev_size_bad(ev_size_bad)
);

// File: tb/nbt_read_target_bench.sv
`timescale 1ns/100ps
module nbt_read_target_bench;

  localparam logic [3:0] MY_ID = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic        mem_req;
  logic [27:0] mem_addr;
  logic [7:0]  mem_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nbt_read_target u_nbt_read_target (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .bus_in  (bus_in),
    .dev_id  (MY_ID),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .mem_req (mem_req),
    .mem_addr(mem_addr),
    .mem_data(mem_data)
  );

  function automatic logic [7:0] mem_fn(input logic [27:0] a);
    return a[7:0] ^ {a[27:24], a[11:8]} ^ 8'hA5;
  endfunction

  // Memory: correct byte only on the clock after a request, garbage otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mem_data <= 8'h00;
    else if (mem_req) mem_data <= mem_fn(mem_addr);
    else              mem_data <= ~mem_data;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_clk(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    frame_n = fr;
    bus_in  = nib;
  endtask

  // One frame. Clock k outputs are checked at the falling edge before clock k.
  task automatic send_read(input bit pre_en, input logic [3:0] pre_nib,
                           input logic [3:0] start_nib, input logic [3:0] sel,
                           input logic [27:0] addr, input logic [3:0] size,
                           input string tag);
    bit         hit;
    bit         req_exp;
    logic [7:0] d;
    logic [3:0] exp_nib;
    req_exp = (start_nib == 4'b1101) && (sel == MY_ID);
    hit     = req_exp && (size == 4'b0000);
    d       = mem_fn(addr);
    if (pre_en) idle_clk(1'b0, pre_nib);
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        bit exp_oe;
        exp_oe = hit && (k >= 13) && (k <= 16);
        chk(bus_oe == exp_oe, hit ? "R7" : tag, 32'(bus_oe), 32'(exp_oe));
        chk(mem_req == (req_exp && k == 10), req_exp ? "R5" : tag,
            32'(mem_req), 32'(req_exp && k == 10));
        if (req_exp && k == 10)
          chk(mem_addr == addr, "R5", 32'(mem_addr), 32'(addr));
        if (exp_oe) begin
          case (k)
            13:      exp_nib = 4'b0000;
            14:      exp_nib = d[3:0];
            15:      exp_nib = d[7:4];
            default: exp_nib = 4'b1111;
          endcase
          chk(bus_out == exp_nib, (k == 14 || k == 15) ? "R9" : "R8",
              32'(bus_out), 32'(exp_nib));
        end
      end
      frame_n = (k == 1) ? 1'b0 : 1'b1;
      case (k)
        1:       bus_in = start_nib;
        2:       bus_in = sel;
        3, 4, 5, 6, 7, 8, 9: bus_in = addr[(9-k)*4 +: 4];
        10:      bus_in = size;
        default: bus_in = 4'hF;
      endcase
    end
  endtask

  task automatic t_reset;
    chk(!bus_oe && !mem_req, "R1", {bus_oe, mem_req}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(!bus_oe && !mem_req, "R1", {bus_oe, mem_req}, 0);
    end
  endtask

  task automatic t_start_rules;
    for (int i = 0; i < 4; i++) begin
      idle_clk(1'b1, 4'b1101);
      @(posedge clk);
    end
    for (int i = 0; i < 12; i++) begin
      idle_clk(1'b1, (i == 0) ? MY_ID : 4'h0);
      chk(!bus_oe && !mem_req, "R2", {bus_oe, mem_req}, 0);
    end
    send_read(1'b0, 4'h0, 4'h5, MY_ID, 28'h0123456, 4'h0, "R2");
  endtask

  task automatic t_basic;
    send_read(1'b0, 4'h0, 4'b1101, MY_ID, 28'h1234567, 4'h0, "R5");
    send_read(1'b0, 4'h0, 4'b1101, MY_ID, 28'hFEDCBA9, 4'h0, "R8");
    send_read(1'b0, 4'h0, 4'b1101, MY_ID, 28'h0000000, 4'h0, "R8");
    send_read(1'b0, 4'h0, 4'b1101, MY_ID, 28'hFFFFFFF, 4'h0, "R8");
  endtask

  task automatic t_requal;
    send_read(1'b1, 4'h3, 4'b1101, MY_ID, 28'h0A5A5A5, 4'h0, "R3");
    send_read(1'b1, 4'b1101, 4'h2, MY_ID, 28'h05A5A5A, 4'h0, "R3");
  endtask

  task automatic t_sel_miss;
    send_read(1'b0, 4'h0, 4'b1101, 4'h5, 28'h1111111, 4'h0, "R4");
    send_read(1'b0, 4'h0, 4'b1101, ~MY_ID, 28'h2222222, 4'h0, "R4");
  endtask

  task automatic t_size_bad;
    send_read(1'b0, 4'h0, 4'b1101, MY_ID, 28'h3333333, 4'h1, "R6");
    send_read(1'b0, 4'h0, 4'b1101, MY_ID, 28'h4444444, 4'hF, "R6");
  endtask

  task automatic abort_prefix;
    idle_clk(1'b0, 4'b1101);
    idle_clk(1'b1, MY_ID);
    for (int i = 0; i < 3; i++) idle_clk(1'b1, 4'h9);
  endtask

  task automatic t_abort;
    abort_prefix();
    idle_clk(1'b0, 4'h0);
    for (int i = 0; i < 14; i++) begin
      idle_clk(1'b1, 4'hF);
      chk(!bus_oe && !mem_req, "R10", {bus_oe, mem_req}, 0);
    end
    abort_prefix();
    send_read(1'b0, 4'h0, 4'b1101, MY_ID, 28'h9876543, 4'h0, "R10");
  endtask

  initial begin
    t_reset();
    t_start_rules();
    t_basic();
    t_requal();
    t_sel_miss();
    t_size_bad();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule